// File: doc/BRIEF.md
# SDRAM Read/Write Data Path with CAS Latency and Byte Masks

This block sits between an SDRAM command sequencer and the storage array of a 16-bit SDRAM device. It turns read and write commands into per-cycle column beats: it walks the burst addresses, sends write data straight to the array with per-byte enables, and returns read data on the data bus after a programmable CAS latency of 1, 2 or 3 clocks.

The two byte masks act differently on the two directions. During a write, a mask bit blocks its byte on the same clock. During a read, a mask bit sampled in one cycle turns that byte's output driver off two cycles later, whatever the CAS latency. A burst stop (or a precharge, signalled on the same pin) ends the burst at once. Read beats already issued still come out, so the number of trailing beats on the bus follows from the CAS latency.

The sequencer drives one command pulse per command. The array is modelled outside the block: it takes an address, a read strobe, a write strobe with byte enables and write data, and it returns read data in the same cycle.

Top module: `sdr_dpath`

## Requirements
- R1: A read beat issued in cycle t appears on `dq_o` in cycle t+CL, where CL is `cas_lat` (1, 2 or 3). Byte lanes that are not masked have their `dq_oe` bit high in that cycle.
- R2: A command starts a burst of 1, 2, 4 or 8 beats for `bl_sel` = 0, 1, 2, 3, one beat per cycle from the command cycle onward. The burst mode is latched at the command. With `burst_ilv`=0 the beat k address is the start column with its low log2(length) bits replaced by (start+k) mod length.
- R3: With `burst_ilv`=1 the low log2(length) bits of the beat k address are the start column's low bits XOR k. The upper bits are kept.
- R4: A write beat raises `arr_we` in its own cycle with `arr_wdata`=`dq_i`. `arr_wbe[0]`=!`dqm[0]` covers bits 7:0 and `arr_wbe[1]`=!`dqm[1]` covers bits 15:8, so a masked byte is not written (mask latency 0).
- R5: `dqm[b]` high in cycle t forces `dq_oe[b]` low in cycle t+2 for any CAS latency. The burst keeps advancing its addresses under a mask.
- R6: `stop_cmd` issues no beat in its cycle and ends the burst. A `rd_cmd` or `wr_cmd` in the same cycle is ignored. The number of read beats still driven after the stop is CL-1: 2, 1 or 0.
- R7: A new command during a burst restarts from the new column. Read beats issued before it are still delivered.
- R8: `dq_oe` is low in every cycle that carries no valid read beat, including the cycle after the last beat. While reset is asserted `dq_oe` stays low.
- R9: If `rd_cmd` and `wr_cmd` are both high, the read is taken and no write strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat | input | 2 | CAS latency, 1 to 3; changed only while no read is in flight |
| bl_sel | input | 2 | Burst length code: 1, 2, 4 or 8 beats |
| burst_ilv | input | 1 | 0 sequential, 1 interleaved address order |
| rd_cmd | input | 1 | Read command pulse |
| wr_cmd | input | 1 | Write command pulse |
| stop_cmd | input | 1 | Burst stop or precharge pulse |
| col_in | input | COL_W | Start column of a command |
| dqm | input | 2 | Byte masks: bit 0 lower byte, bit 1 upper byte |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data to the bus |
| dq_oe | output | 2 | Per-byte output enable |
| arr_addr | output | COL_W | Array column address of the current beat |
| arr_rd | output | 1 | Array read strobe |
| arr_rdata | input | 16 | Array read data, same cycle as `arr_rd` |
| arr_we | output | 1 | Array write strobe |
| arr_wbe | output | 2 | Array byte write enables |
| arr_wdata | output | 16 | Array write data |

## Verification
The assertions check on every cycle that:
- a stop never carries a beat, and a read wins over a write;
- a write mask removes its byte enable in the same cycle;
- no enabled output byte follows a mask bit from two cycles earlier;
- each read strobe produces valid data exactly CAS-latency cycles later, and valid data always has a strobe that many cycles back.

Burst address orders, data integrity through the array, the count of trailing beats after a stop for each CAS latency, and the restart of an interrupted read show up only in the bench scenarios. There a behavioural model compares every strobe, address, enable and data byte cycle by cycle.

// File: rtl/sdr_dpath_pkg.sv
package sdr_dpath_pkg;

  typedef enum logic [1:0] {
    BLEN_1 = 2'd0,
    BLEN_2 = 2'd1,
    BLEN_4 = 2'd2,
    BLEN_8 = 2'd3
  } blen_e;

  // Index of the final beat of a burst, from its length code.
  function automatic logic [3:0] last_idx(input logic [1:0] code);
    return 4'((1 << code) - 1);
  endfunction

  // Column of beat idx: low bits wrap inside the burst block,
  // either by adding (sequential) or by XOR (interleaved).
  function automatic logic [15:0] burst_col(input logic [15:0] start,
                                            input logic [3:0]  idx,
                                            input logic [1:0]  code,
                                            input logic        ilv);
    logic [15:0] wrap_m;
    logic [15:0] off;
    wrap_m = 16'((1 << code) - 1);
    off    = ilv ? (start ^ {12'd0, idx}) : (start + {12'd0, idx});
    return (start & ~wrap_m) | (off & wrap_m);
  endfunction

  // Pipeline tap for a CAS latency; a zero code behaves as latency 1.
  function automatic logic [1:0] cl_tap(input logic [1:0] cl);
    return (cl == 2'd0) ? 2'd0 : 2'(cl - 2'd1);
  endfunction

endpackage

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_dpath_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd,
  input  logic             wr_cmd,
  input  logic             stop_cmd,
  input  logic [COL_W-1:0] col_in,
  input  logic [1:0]       bl_sel,
  input  logic             burst_ilv,
  output logic             beat_vld,
  output logic             beat_rd,
  output logic [COL_W-1:0] beat_col
);
  localparam int IDX_W = 4;

  logic             act_q, rd_q, ilv_q;
  logic [1:0]       code_q;
  logic [COL_W-1:0] start_q;
  logic [IDX_W-1:0] idx_q;

  logic             take_new;
  logic             beat_last;
  logic [COL_W-1:0] cur_start;
  logic [IDX_W-1:0] cur_idx;
  logic [1:0]       cur_code;
  logic             cur_ilv;
  logic [15:0]      col_wide;

  assign take_new = (rd_cmd | wr_cmd) & ~stop_cmd;

  always_comb begin
    cur_start = take_new ? col_in    : start_q;
    cur_idx   = take_new ? '0        : idx_q;
    cur_code  = take_new ? bl_sel    : code_q;
    cur_ilv   = take_new ? burst_ilv : ilv_q;
    beat_vld  = take_new | (act_q & ~stop_cmd);
    beat_rd   = take_new ? rd_cmd : rd_q;
  end

  assign col_wide  = burst_col(16'(cur_start), cur_idx, cur_code, cur_ilv);
  assign beat_col  = col_wide[COL_W-1:0];
  assign beat_last = (cur_idx == last_idx(cur_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      ilv_q   <= 1'b0;
      code_q  <= BLEN_1;
      start_q <= '0;
      idx_q   <= '0;
    end else if (stop_cmd) begin
      act_q <= 1'b0;
    end else if (beat_vld) begin
      act_q   <= ~beat_last;
      rd_q    <= beat_rd;
      start_q <= cur_start;
      idx_q   <= cur_idx + 1'b1;
      code_q  <= cur_code;
      ilv_q   <= cur_ilv;
    end
  end
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe
  import sdr_dpath_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NB       = DW / 8,
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cas_lat,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  input  logic [NB-1:0] dqm,
  output logic          out_vld,
  output logic [DW-1:0] dq_o,
  output logic [NB-1:0] dq_oe
);
  logic          vld_q [MAX_CL];
  logic [DW-1:0] dat_q [MAX_CL];
  logic [NB-1:0] msk_q [MASK_LAT];
  logic [1:0]    tap;

  // Data and valid shift one stage per clock; the tap picks the latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < MAX_CL; s++) begin
        vld_q[s] <= 1'b0;
        dat_q[s] <= '0;
      end
    end else begin
      vld_q[0] <= in_vld;
      dat_q[0] <= in_vld ? in_data : dat_q[0];
      for (int s = MAX_CL - 1; s > 0; s--) begin
        vld_q[s] <= vld_q[s-1];
        dat_q[s] <= dat_q[s-1];
      end
    end
  end

  // Masks follow a fixed delay, independent of the CAS latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < MASK_LAT; s++) msk_q[s] <= '0;
    end else begin
      msk_q[0] <= dqm;
      for (int s = MASK_LAT - 1; s > 0; s--) msk_q[s] <= msk_q[s-1];
    end
  end

  always_comb begin
    tap = cl_tap(cas_lat);
    if (int'(tap) >= MAX_CL) tap = 2'(MAX_CL - 1);
  end

  assign out_vld = vld_q[tap];
  assign dq_o    = dat_q[tap];

  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane_oe
      assign dq_oe[b] = out_vld & ~msk_q[MASK_LAT-1][b];
    end
  endgenerate
endmodule

// File: rtl/sdr_wr_path.sv
module sdr_wr_path #(
  parameter int DW = 16,
  parameter int NB = DW / 8
) (
  input  logic          beat_vld,
  input  logic          beat_rd,
  input  logic [DW-1:0] dq_i,
  input  logic [NB-1:0] dqm,
  output logic          arr_we,
  output logic [NB-1:0] arr_wbe,
  output logic [DW-1:0] arr_wdata
);
  assign arr_we = beat_vld & ~beat_rd;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane_wr
      assign arr_wbe[b]         = arr_we & ~dqm[b];
      assign arr_wdata[8*b +: 8] = dq_i[8*b +: 8];
    end
  endgenerate
endmodule

// File: rtl/sdr_dpath.sv
module sdr_dpath
  import sdr_dpath_pkg::*;
#(
  parameter int COL_W       = 9,
  parameter int DW          = 16,
  parameter int MAX_CL      = 3,
  parameter int RD_MASK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cas_lat,
  input  logic [1:0]        bl_sel,
  input  logic              burst_ilv,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic              stop_cmd,
  input  logic [COL_W-1:0]  col_in,
  input  logic [DW/8-1:0]   dqm,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic [DW/8-1:0]   dq_oe,
  output logic [COL_W-1:0]  arr_addr,
  output logic              arr_rd,
  input  logic [DW-1:0]     arr_rdata,
  output logic              arr_we,
  output logic [DW/8-1:0]   arr_wbe,
  output logic [DW-1:0]     arr_wdata
);
  localparam int NB = DW / 8;

  // Named internal events, visible to the bound checker.
  logic             beat_vld;
  logic             beat_rd;
  logic [COL_W-1:0] beat_col;
  logic             rd_beat;
  logic             out_vld;

  sdr_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_cmd    (rd_cmd),
    .wr_cmd    (wr_cmd),
    .stop_cmd  (stop_cmd),
    .col_in    (col_in),
    .bl_sel    (bl_sel),
    .burst_ilv (burst_ilv),
    .beat_vld  (beat_vld),
    .beat_rd   (beat_rd),
    .beat_col  (beat_col)
  );

  assign rd_beat  = beat_vld & beat_rd;
  assign arr_rd   = rd_beat;
  assign arr_addr = beat_col;

  sdr_rd_pipe #(.DW(DW), .NB(NB), .MAX_CL(MAX_CL), .MASK_LAT(RD_MASK_LAT)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cas_lat (cas_lat),
    .in_vld  (rd_beat),
    .in_data (arr_rdata),
    .dqm     (dqm),
    .out_vld (out_vld),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe)
  );

  sdr_wr_path #(.DW(DW), .NB(NB)) u_wr (
    .beat_vld  (beat_vld),
    .beat_rd   (beat_rd),
    .dq_i      (dq_i),
    .dqm       (dqm),
    .arr_we    (arr_we),
    .arr_wbe   (arr_wbe),
    .arr_wdata (arr_wdata)
  );
endmodule

// File: rtl/sdr_dpath_chk.sv
module sdr_dpath_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cas_lat,
  input logic          rd_cmd,
  input logic          wr_cmd,
  input logic          stop_cmd,
  input logic [NB-1:0] dqm,
  input logic          beat_vld,
  input logic          out_vld,
  input logic [NB-1:0] dq_oe,
  input logic          arr_rd,
  input logic          arr_we,
  input logic [NB-1:0] arr_wbe
);
  AST_STOP_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |-> !beat_vld); // R6

  AST_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && wr_cmd && !stop_cmd) |-> (arr_rd && !arr_we)); // R9

  AST_CL1_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd1 && arr_rd) |=> out_vld); // R1

  AST_CL2_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd2 && arr_rd) |-> ##2 out_vld); // R1

  AST_CL3_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd3 && arr_rd) |-> ##3 out_vld); // R1

  AST_CL3_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd3 && out_vld) |-> $past(arr_rd, 3)); // R8

  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane_chk
      AST_WR_MASK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && dqm[b]) |-> !arr_wbe[b]); // R4

      AST_RD_MASK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe[b] |-> !$past(dqm[b], 2)); // R5
    end
  endgenerate
endmodule

bind sdr_dpath sdr_dpath_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cas_lat  (cas_lat),
  .rd_cmd   (rd_cmd),
  .wr_cmd   (wr_cmd),
  .stop_cmd (stop_cmd),
  .dqm      (dqm),
  .beat_vld (beat_vld),
  .out_vld  (out_vld),
  .dq_oe    (dq_oe),
  .arr_rd   (arr_rd),
  .arr_we   (arr_we),
  .arr_wbe  (arr_wbe)
);

// File: tb/sdr_dpath_tb.sv
`timescale 1ns/1ps
module sdr_dpath_tb;
  localparam int COL_W = 9;
  localparam int DEPTH = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]       cas_lat = 2'd3;
  logic [1:0]       bl_sel = 2'd0;
  logic             burst_ilv = 1'b0;
  logic             rd_cmd = 1'b0, wr_cmd = 1'b0, stop_cmd = 1'b0;
  logic [COL_W-1:0] col_in = '0;
  logic [1:0]       dqm = 2'b00;
  logic [15:0]      dq_i = '0;
  wire  [15:0]      dq_o;
  wire  [1:0]       dq_oe;
  wire  [COL_W-1:0] arr_addr;
  wire              arr_rd, arr_we;
  wire  [1:0]       arr_wbe;
  wire  [15:0]      arr_wdata;
  logic [15:0]      arr_rdata;

  logic [15:0] mem     [DEPTH];
  logic [15:0] ref_mem [DEPTH];

  sdr_dpath u_dut (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .bl_sel(bl_sel),
    .burst_ilv(burst_ilv), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .stop_cmd(stop_cmd), .col_in(col_in), .dqm(dqm), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe(dq_oe), .arr_addr(arr_addr), .arr_rd(arr_rd),
    .arr_rdata(arr_rdata), .arr_we(arr_we), .arr_wbe(arr_wbe),
    .arr_wdata(arr_wdata)
  );

  // Array model driven by the design's strobes.
  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) begin
    if (arr_we) begin
      if (arr_wbe[0]) mem[arr_addr][7:0]  <= arr_wdata[7:0];
      if (arr_wbe[1]) mem[arr_addr][15:8] <= arr_wdata[15:8];
    end
  end

  int errors = 0, checks = 0, cyc = 0, oe_cnt = 0;
  bit done = 0;
  // Behavioural model state
  bit m_act = 0, m_rd = 0, m_ilv = 0;
  int m_start = 0, m_k = 0, m_len = 1;
  bit          sv_vld [8];
  logic [15:0] sv_dat [8];
  logic [1:0]  sv_msk [8];

  function automatic int ref_col(int s, int k, int len, bit ilv);
    int base, off;
    base = s - (s % len);
    off  = s % len;
    if (ilv) return base + (off ^ k);
    return base + ((off + k) % len);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic idle_in();
    rd_cmd = 0; wr_cmd = 0; stop_cmd = 0; dqm = 2'b00;
  endtask

  // One cycle: inputs are already set; compare, advance model, wait.
  task automatic step();
    int ecl, col, s;
    bit beat, brd;
    logic [1:0] eoe;
    string rq;
    #1;
    ecl = (cas_lat == 2'd0) ? 1 : int'(cas_lat);
    beat = 0; brd = 0; col = 0;
    if (stop_cmd) m_act = 0;
    else if (rd_cmd || wr_cmd) begin
      m_rd = rd_cmd; m_start = int'(col_in); m_k = 0;
      m_len = 1 << bl_sel; m_ilv = burst_ilv; m_act = 1;
    end
    if (!stop_cmd && m_act) begin
      beat = 1; brd = m_rd;
      col = ref_col(m_start, m_k, m_len, m_ilv);
      m_k++;
      if (m_k >= m_len) m_act = 0;
    end
    rq = (rd_cmd && wr_cmd && !stop_cmd) ? "R9" : (stop_cmd ? "R6" : "R2");
    chk(arr_rd === (beat && brd), rq, "arr_rd", int'(arr_rd), int'(beat && brd));
    chk(arr_we === (beat && !brd), beat ? "R4" : rq, "arr_we", int'(arr_we), int'(beat && !brd));
    if (beat) begin
      chk(int'(arr_addr) == col, m_ilv ? "R3" : "R2", "arr_addr", int'(arr_addr), col);
      if (brd) begin
        s = (cyc + ecl) % 8;
        sv_vld[s] = 1;
        sv_dat[s] = ref_mem[col];
      end else begin
        chk(arr_wdata === dq_i, "R4", "arr_wdata", int'(arr_wdata), int'(dq_i));
        chk(arr_wbe === ~dqm, "R4", "arr_wbe", int'(arr_wbe), int'(~dqm));
        if (!dqm[0]) ref_mem[col][7:0]  = dq_i[7:0];
        if (!dqm[1]) ref_mem[col][15:8] = dq_i[15:8];
      end
    end
    s = cyc % 8;
    eoe = {sv_vld[s] && !sv_msk[s][1], sv_vld[s] && !sv_msk[s][0]};
    rq = !sv_vld[s] ? "R8" : ((sv_msk[s] != 2'b00) ? "R5" : "R1");
    chk(dq_oe === eoe, rq, "dq_oe", int'(dq_oe), int'(eoe));
    if (eoe[0]) chk(dq_o[7:0] === sv_dat[s][7:0], "R1", "dq_o[7:0]", int'(dq_o[7:0]), int'(sv_dat[s][7:0]));
    if (eoe[1]) chk(dq_o[15:8] === sv_dat[s][15:8], "R1", "dq_o[15:8]", int'(dq_o[15:8]), int'(sv_dat[s][15:8]));
    if (dq_oe != 2'b00) oe_cnt++;
    sv_vld[s] = 0;
    sv_msk[(cyc + 2) % 8] = dqm;
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_idle(input int n);
    idle_in();
    for (int i = 0; i < n; i++) begin
      dq_i = 16'($urandom);
      step();
    end
  endtask

  task automatic command(input bit rd, input int col, input int bl, input bit ilv,
                         input logic [1:0] m);
    rd_cmd = rd; wr_cmd = !rd; col_in = COL_W'(col);
    bl_sel = 2'(bl); burst_ilv = ilv; dqm = m; dq_i = 16'($urandom);
    step();
    idle_in();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 16'(i * 40503 + 7);
      ref_mem[i] = mem[i];
    end
    for (int i = 0; i < 8; i++) begin
      sv_vld[i] = 0; sv_dat[i] = '0; sv_msk[i] = 2'b00;
    end
    // Reset: pulsing reads must not drive the bus (R8)
    rd_cmd = 1;
    repeat (4) @(negedge clk);
    chk(dq_oe === 2'b00, "R8", "dq_oe in reset", int'(dq_oe), 0);
    rd_cmd = 0;
    @(negedge clk);
    chk(dq_oe === 2'b00, "R8", "dq_oe in reset", int'(dq_oe), 0);
    rst_n = 1;

    // Masked write burst (R4)
    cas_lat = 2'd3;
    command(0, 16, 3, 0, 2'b01);
    for (int i = 1; i < 8; i++) begin
      dqm = 2'(i % 4); dq_i = 16'($urandom); step();
    end
    run_idle(2);

    // Reads at each latency, both orders, with read masks (R1 R2 R3 R5)
    for (int cl = 1; cl <= 3; cl++) begin
      cas_lat = 2'(cl);
      command(1, 16, 3, 0, 2'b00);
      run_idle(8);
      command(1, 22, 2, 1, 2'b10);
      dqm = 2'b01; step();
      run_idle(6);
      command(1, 13, 3, 1, 2'b00);
      dqm = 2'b11; step();
      run_idle(9);
      command(1, 9, 1, 0, 2'b00);
      command(1, 30, 0, 0, 2'b00);
      run_idle(6);
    end

    // Trailing beats after stop: CL-1 (R6)
    for (int cl = 1; cl <= 3; cl++) begin
      cas_lat = 2'(cl);
      run_idle(4);
      command(1, 40, 3, 0, 2'b00);
      run_idle(3);
      stop_cmd = 1; step(); idle_in();
      oe_cnt = 0;
      run_idle(6);
      chk(oe_cnt == cl - 1, "R6", "beats after stop", oe_cnt, cl - 1);
    end

    // Stop beside a read: read ignored (R6)
    cas_lat = 2'd2;
    oe_cnt = 0;
    rd_cmd = 1; stop_cmd = 1; col_in = 5; step(); idle_in();
    run_idle(6);
    chk(oe_cnt == 0, "R6", "read beside stop", oe_cnt, 0);

    // Read then write in one cycle: read taken (R9)
    rd_cmd = 1; wr_cmd = 1; col_in = 60; bl_sel = 2'd1; step(); idle_in();
    run_idle(6);

    // Read restarted after 2 beats: 2 + 2 beats delivered (R7)
    cas_lat = 2'd3;
    oe_cnt = 0;
    command(1, 64, 3, 0, 2'b00);
    step();
    command(1, 100, 1, 1, 2'b00);
    run_idle(8);
    chk(oe_cnt == 4, "R7", "beats of restarted read", oe_cnt, 4);

    // Write cut by stop, then read back
    command(0, 16, 3, 0, 2'b00);
    dq_i = 16'($urandom); step();
    stop_cmd = 1; step(); idle_in();
    command(1, 16, 3, 0, 2'b00);
    run_idle(10);

    // Random traffic at each latency
    for (int cl = 1; cl <= 3; cl++) begin
      run_idle(6);
      cas_lat = 2'(cl);
      for (int i = 0; i < 700; i++) begin
        int r;
        r = int'($urandom % 100);
        rd_cmd   = (r < 8) || (r >= 20 && r < 22);
        wr_cmd   = (r >= 8 && r < 22);
        stop_cmd = (r >= 16 && r < 20);
        col_in   = COL_W'($urandom);
        bl_sel   = 2'($urandom);
        burst_ilv = 1'($urandom);
        dqm      = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
        dq_i     = 16'($urandom);
        step();
      end
      run_idle(8);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule